// File: doc/BRIEF.md
# SD Command and Response Engine

This block drives one SD card command on the CMD line and collects the card's reply. Software sets up a command word and a timeout count. It then writes the 32-bit argument, and that write starts the transaction. The engine sends a 48-bit frame protected by CRC7, one bit per SD clock enable strobe. When the command word asks for a reply, the engine receives a 48-bit or 136-bit response, checks it, and reports the outcome in a sticky status register. Status bits that are enabled can raise an interrupt.

The command word selects the response length, and whether to wait for the card to release DAT0 after the reply. It also selects whether the reply's CRC and its echoed index are checked. A single counter of SD clock strobes limits both the wait for the response start bit and the busy wait. Every error raises a shared error flag together with its own cause bit. The completion flag is raised only when the command ends cleanly.

The SD clock itself, the data lines and the bus fabric are outside this block. Writes arrive on a simple write port. The status and response words are presented as outputs.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, status, all response words and irq are 0, cmd_oe is 0 and cmd_out is 1.
- R2: Writing address 0 while idle launches a frame of 48 bits, sent MSB first, one bit per strobe, with cmd_oe high for exactly those 48 strobes. The frame is {0, 1, command word bits [13:8], argument, CRC7, 1}. The CRC7 uses polynomial x^7+x^3+1, starts at zero and covers the first 40 bits.
- R3: A command word with bits [1:0] = 0 expects no response. It ends after the frame (and after any busy wait) with status exactly 0x01. Bit 0 is set only on an error-free finish.
- R4: Bits [1:0] = 1 (or 3) expect a 48-bit response. The response starts at the first 0 on cmd_in after the frame. Response bits 8..39 are placed in rsp_w1.
- R5: Bits [1:0] = 2 expect a 136-bit response. Response bits 8..135 are placed in rsp_w1..rsp_w4, with rsp_w1 most significant.
- R6: With command bit 3 set, a CRC mismatch ends the command with status 0x0A. For a short response the CRC covers response bits 0..39; for a long response it covers bits 8..127. With bit 3 clear, a mismatch is not reported.
- R7: With command bit 4 set, a short response whose bits 2..7 differ from the command index ends with status 0x12. A long response is never index checked.
- R8: A nonzero timeout value T ends the command with status 0x06 if no start bit is seen within the first T strobes after the frame. A start bit on strobe T-1 (counting from 0) is still accepted. A value of 0 waits forever.
- R9: With command bit 2 set, completion waits until dat0_in is high on a strobe. This wait has its own timeout of T strobes and gives status 0x06 when it expires.
- R10: A write to address 3 ANDs the status with wr_data[4:0], so writing 0 clears it.
- R11: irq is high exactly when the status ANDed with the enable written at address 4 is nonzero.
- R12: While a command is in progress, writes to addresses 0, 1 (command word) and 2 (timeout) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_strobe | input | 1 | One-cycle SD clock enable; all line activity advances on it |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 argument/launch, 1 command word, 2 timeout, 3 status, 4 irq enable |
| wr_data | input | 32 | Write data |
| cmd_in | input | 1 | CMD line as seen from the card |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| cmd_out | output | 1 | CMD drive value |
| cmd_oe | output | 1 | CMD drive enable |
| status | output | 5 | Bit 0 done, 1 error, 2 timeout, 3 CRC, 4 index |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 |
| rsp_w4 | output | 32 | Response word 4 |
| irq | output | 1 | Command interrupt |

## Verification
The hardest situations to reach are an early start bit at the exact edge of the timeout window, and a write that tries to relaunch or retarget a command while it is in flight. The bench card model counts strobes from the end of the outgoing frame. It places the reply start one strobe before and one strobe at the limit. In the flight test, it fires a new command word and a new argument midway through the frame. The index check then shows whether the command word changed, and the frame length shows whether a second launch happened.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CNT_W      = $clog2(LONG_BITS);

    localparam logic [2:0] RA_ARG = 3'd0;
    localparam logic [2:0] RA_CMD = 3'd1;
    localparam logic [2:0] RA_TMO = 3'd2;
    localparam logic [2:0] RA_STS = 3'd3;
    localparam logic [2:0] RA_IEN = 3'd4;

    localparam logic [4:0] STS_OK   = 5'b00001;
    localparam logic [4:0] STS_TMO  = 5'b00110;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TX   = 3'd1,
        ST_WAIT = 3'd2,
        ST_RX   = 3'd3,
        ST_BUSY = 3'd4
    } sdcmd_state_e;

    // One step of the x^7+x^3+1 divider.
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    // Full outgoing frame, CRC computed over the 40 leading bits.
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [5:0] idx,
                                                          input logic [31:0] arg);
        logic [39:0] head;
        logic [6:0]  c;
        head = {2'b01, idx, arg};
        c    = '0;
        for (int i = 39; i >= 0; i--) begin
            c = crc7_step(c, head[i]);
        end
        return {head, c, 1'b1};
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    import sdcmd_pkg::*;

    logic [6:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = crc7_step(crc_q, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    // A limit of zero never expires.
    assign expired = tick && !clr && (limit != '0) && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine #(
    parameter int TMO_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sd_strobe,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        cmd_in,
    input  logic        dat0_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic [4:0]  status,
    output logic [31:0] rsp_w1,
    output logic [31:0] rsp_w2,
    output logic [31:0] rsp_w3,
    output logic [31:0] rsp_w4,
    output logic        irq
);
    import sdcmd_pkg::*;

    localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 1);

    typedef struct packed {
        sdcmd_state_e           state;
        logic [CNT_W-1:0]       cnt;
        logic [LONG_BITS-1:0]   sh;
        logic [5:0]             idx;
        logic [4:0]             flg;   // [1:0] reply kind, [2] busy, [3] crc, [4] index
        logic [TMO_W-1:0]       tmo;
        logic [4:0]             sts;
        logic [4:0]             ien;
        logic [3:0][31:0]       rsp;
    } regs_t;

    regs_t r_q, r_d;

    logic       crc_clr, crc_en;
    logic [6:0] crc_val;
    logic       tmr_clr, tmr_tick, tmr_exp;
    logic       is_long, no_rsp, in_crc_span;
    logic       crc_bad, idx_bad;
    logic [4:0] set_bits;

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (cmd_in),
        .crc   (crc_val)
    );

    sdcmd_timer #(.W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tmr_tick),
        .limit   (r_q.tmo),
        .expired (tmr_exp)
    );

    assign is_long = (r_q.flg[1:0] == 2'd2);
    assign no_rsp  = (r_q.flg[1:0] == 2'd0);

    // Bits fed to the divider include the received CRC, so a match leaves zero.
    assign in_crc_span = is_long ? (r_q.cnt >= CNT_W'(8) && r_q.cnt <= LONG_LAST - 1'b1)
                                 : (r_q.cnt >= CNT_W'(1) && r_q.cnt <= SHORT_LAST - 1'b1);
    assign crc_bad = r_q.flg[3] && (crc_val != 7'd0);
    assign idx_bad = r_q.flg[4] && !is_long && (r_q.sh[44:39] != r_q.idx);

    always_comb begin
        r_d      = r_q;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        tmr_clr  = 1'b0;
        tmr_tick = 1'b0;
        set_bits = '0;

        if (wr_en) begin
            unique case (wr_addr)
                RA_ARG: if (r_q.state == ST_IDLE) begin
                    r_d.state = ST_TX;
                    r_d.cnt   = '0;
                    r_d.sh    = {{(LONG_BITS-FRAME_BITS){1'b0}}, build_frame(r_q.idx, wr_data)};
                end
                RA_CMD: if (r_q.state == ST_IDLE) begin
                    r_d.idx = wr_data[13:8];
                    r_d.flg = wr_data[4:0];
                end
                RA_TMO: if (r_q.state == ST_IDLE) r_d.tmo = wr_data[TMO_W-1:0];
                RA_STS: r_d.sts = r_q.sts & wr_data[4:0];
                RA_IEN: r_d.ien = wr_data[4:0];
                default: ;
            endcase
        end

        if (sd_strobe) begin
            unique case (r_q.state)
                ST_TX: begin
                    r_d.sh  = r_q.sh << 1;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == TX_LAST) begin
                        r_d.cnt = '0;
                        r_d.sh  = '0;
                        crc_clr = 1'b1;
                        tmr_clr = 1'b1;
                        if (!no_rsp)          r_d.state = ST_WAIT;
                        else if (r_q.flg[2])  r_d.state = ST_BUSY;
                        else begin
                            r_d.state = ST_IDLE;
                            set_bits  = STS_OK;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!cmd_in) begin
                        r_d.state = ST_RX;
                        r_d.cnt   = CNT_W'(1);
                        r_d.sh    = r_q.sh << 1;
                    end else begin
                        tmr_tick = 1'b1;
                        if (tmr_exp) begin
                            r_d.state = ST_IDLE;
                            set_bits  = STS_TMO;
                        end
                    end
                end
                ST_RX: begin
                    r_d.sh  = (r_q.sh << 1) | {{(LONG_BITS-1){1'b0}}, cmd_in};
                    r_d.cnt = r_q.cnt + 1'b1;
                    crc_en  = in_crc_span;
                    if (r_q.cnt == (is_long ? LONG_LAST : SHORT_LAST)) begin
                        if (is_long) r_d.rsp    = {r_q.sh[126:0], cmd_in};
                        else         r_d.rsp[3] = r_q.sh[38:7];
                        if (crc_bad || idx_bad) begin
                            r_d.state = ST_IDLE;
                            set_bits  = {idx_bad, crc_bad, 1'b0, 1'b1, 1'b0};
                        end else if (r_q.flg[2]) begin
                            r_d.state = ST_BUSY;
                            tmr_clr   = 1'b1;
                        end else begin
                            r_d.state = ST_IDLE;
                            set_bits  = STS_OK;
                        end
                    end
                end
                ST_BUSY: begin
                    if (dat0_in) begin
                        r_d.state = ST_IDLE;
                        set_bits  = STS_OK;
                    end else begin
                        tmr_tick = 1'b1;
                        if (tmr_exp) begin
                            r_d.state = ST_IDLE;
                            set_bits  = STS_TMO;
                        end
                    end
                end
                default: ;
            endcase
        end

        r_d.sts = r_d.sts | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_oe  = (r_q.state == ST_TX);
    assign cmd_out = (r_q.state == ST_TX) ? r_q.sh[FRAME_BITS-1] : 1'b1;
    assign status  = r_q.sts;
    assign rsp_w1  = r_q.rsp[3];
    assign rsp_w2  = r_q.rsp[2];
    assign rsp_w3  = r_q.rsp[1];
    assign rsp_w4  = r_q.rsp[0];
    assign irq     = |(r_q.sts & r_q.ien);
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sd_strobe,
    input logic        wr_en,
    input logic        cmd_oe,
    input logic [4:0]  status,
    input logic [31:0] rsp_w1,
    input logic        irq
);
    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> $past(wr_en));

    // R2
    oe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(sd_strobe));

    // R3
    done_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(sd_strobe));

    // R8
    timeout_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> status[1]);

    // R6
    crc_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> status[1]);

    // R7
    index_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> status[1]);

    // R4
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_strobe |=> $stable(rsp_w1));

    // R11
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 5'd0));
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_strobe (sd_strobe),
    .wr_en     (wr_en),
    .cmd_oe    (cmd_oe),
    .status    (status),
    .rsp_w1    (rsp_w1),
    .irq       (irq)
);

// File: tb/tb_sdcmd_engine.sv
`timescale 1ns/1ps
module tb_sdcmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_strobe = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cmd_in = 1'b1;
    logic        dat0_in = 1'b1;
    logic        cmd_out, cmd_oe, irq;
    logic [4:0]  status;
    logic [31:0] rsp_w1, rsp_w2, rsp_w3, rsp_w4;

    sdcmd_engine dut (
        .clk(clk), .rst_n(rst_n), .sd_strobe(sd_strobe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_in(cmd_in), .dat0_in(dat0_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .status(status),
        .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3), .rsp_w4(rsp_w4),
        .irq(irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int ph = 0;
    bit pw = 1'b0;
    logic [2:0]  pa = '0;
    logic [31:0] pd = '0;

    // card model state
    bit           c_on = 1'b0;
    logic [47:0]  tx_bits;
    int           tx_n, post_k, rsp_len, rsp_dly, busy_len;
    logic [135:0] rsp_vec;
    bit           midw = 1'b0;
    logic [31:0]  mid_cw;

    // scratch
    logic [5:0]   idx;
    logic [31:0]  arg, pl, cw, tmo;
    logic [119:0] d120;
    logic [135:0] lv;
    int           dly;

    function automatic logic [6:0] bcrc(input logic [119:0] v, input int n);
        logic [6:0] c;
        logic fb;
        c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] x, input logic [31:0] a);
        logic [39:0] h;
        h = {2'b01, x, a};
        return {h, bcrc({80'b0, h}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] x, input logic [31:0] p);
        logic [39:0] h;
        h = {2'b00, x, p};
        return {h, bcrc({80'b0, h}, 40), 1'b1, 88'b0};
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] d);
        return {2'b00, 6'h3F, d, bcrc(d, 120), 1'b1};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic card();
        int endk;
        if (cmd_oe) begin
            tx_bits = {tx_bits[46:0], cmd_out};
            tx_n++;
            if (midw && tx_n == 10) begin
                wr_en = 1'b1; wr_addr = 3'd1; wr_data = mid_cw;
            end
            if (midw && tx_n == 20) begin
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h5A5A_0F0F;
            end
        end else if (tx_n >= 48) begin
            if (rsp_len > 0 && post_k >= rsp_dly && post_k < rsp_dly + rsp_len)
                cmd_in = rsp_vec[135 - (post_k - rsp_dly)];
            else
                cmd_in = 1'b1;
            endk = (rsp_len > 0) ? rsp_dly + rsp_len : 0;
            dat0_in = (busy_len == 0) || (post_k - endk >= busy_len);
            post_k++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = pw; wr_addr = pa; wr_data = pd; pw = 1'b0;
        ph = (ph + 1) % 3;
        sd_strobe = (ph == 0);
        if (c_on && sd_strobe) card();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        pw = 1'b1; pa = a; pd = d;
        step();
    endtask

    task automatic run_cmd(input logic [31:0] c, input logic [31:0] t, input logic [31:0] a,
                           input int len, input int dl, input int bl);
        int guard;
        wr(3'd3, 32'd0);
        wr(3'd1, c);
        wr(3'd2, t);
        tx_n = 0; post_k = 0; tx_bits = '0;
        rsp_len = len; rsp_dly = dl; busy_len = bl;
        cmd_in = 1'b1; dat0_in = (bl == 0);
        c_on = 1'b1;
        wr(3'd0, a);
        guard = 0;
        while (status == 5'd0 && guard < 6000) begin
            step();
            guard++;
        end
        c_on = 1'b0; midw = 1'b0; cmd_in = 1'b1; dat0_in = 1'b1;
        step(); step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 status", 64'(status), 64'd0);
        chk("R1 rsp_w1", 64'(rsp_w1), 64'd0);
        chk("R1 rsp_w4", 64'(rsp_w4), 64'd0);
        chk("R1 cmd_oe/out", {62'd0, cmd_oe, cmd_out}, 64'd1);
        chk("R1 irq", 64'(irq), 64'd0);

        // R2/R3 no response
        cw = {18'd0, 6'd0, 3'd0, 5'b00000};
        run_cmd(cw, 32'd0, 32'h0000_0000, 0, 0, 0);
        chk("R2 frame none", 64'(tx_bits), 64'(exp_frame(6'd0, 32'd0)));
        chk("R2 oe strobes", 64'(tx_n), 64'd48);
        chk("R3 status none", 64'(status), 64'd1);

        // R4 random short responses, both checks on
        for (int i = 0; i < 16; i++) begin
            idx = 6'($urandom); arg = $urandom; pl = $urandom; dly = int'($urandom % 7);
            tmo = ($urandom % 2 == 0) ? 32'd0 : 32'd64;
            cw = {18'd0, idx, 3'd0, 5'b11001};
            rsp_vec = mk_short(idx, pl);
            run_cmd(cw, tmo, arg, 48, dly, 0);
            chk("R2 frame short", 64'(tx_bits), 64'(exp_frame(idx, arg)));
            chk("R2 oe strobes", 64'(tx_n), 64'd48);
            chk("R4 rsp_w1", 64'(rsp_w1), 64'(pl));
            chk("R3 status short", 64'(status), 64'd1);
        end

        // R5 long responses, index check requested but not applied (R7)
        for (int i = 0; i < 4; i++) begin
            idx = 6'($urandom); arg = $urandom;
            d120 = {$urandom, $urandom, $urandom, 24'($urandom)};
            lv = mk_long(d120);
            cw = {18'd0, idx, 3'd0, 5'b11010};
            rsp_vec = lv;
            run_cmd(cw, 32'd0, arg, 136, i, 0);
            chk("R5 rsp_w1", 64'(rsp_w1), 64'(lv[127:96]));
            chk("R5 rsp_w2", 64'(rsp_w2), 64'(lv[95:64]));
            chk("R5 rsp_w3", 64'(rsp_w3), 64'(lv[63:32]));
            chk("R5 rsp_w4", 64'(rsp_w4), 64'(lv[31:0]));
            chk("R7 long unchecked", 64'(status), 64'd1);
        end

        // R6 CRC errors
        idx = 6'd17; pl = 32'hCAFE_1234;
        rsp_vec = mk_short(idx, pl);
        rsp_vec[135 - 20] = ~rsp_vec[135 - 20];
        run_cmd({18'd0, idx, 3'd0, 5'b01001}, 32'd0, 32'h1, 48, 2, 0);
        chk("R6 short crc err", 64'(status), 64'h0A);
        run_cmd({18'd0, idx, 3'd0, 5'b00001}, 32'd0, 32'h1, 48, 2, 0);
        chk("R6 crc check off", 64'(status), 64'h01);
        lv = mk_long({4{30'h1234_5678}});
        lv[135 - 100] = ~lv[135 - 100];
        rsp_vec = lv;
        run_cmd({18'd0, 6'd2, 3'd0, 5'b01010}, 32'd0, 32'h2, 136, 1, 0);
        chk("R6 long crc err", 64'(status), 64'h0A);

        // R10 and R11 on the 0x0A status
        wr(3'd3, 32'h08); step();
        chk("R10 and-mask", 64'(status), 64'h08);
        wr(3'd4, 32'h00); step();
        chk("R11 irq masked", 64'(irq), 64'd0);
        wr(3'd4, 32'h08); step();
        chk("R11 irq on", 64'(irq), 64'd1);
        wr(3'd4, 32'h01); step();
        chk("R11 irq other bit", 64'(irq), 64'd0);
        wr(3'd4, 32'h1F); wr(3'd3, 32'h00); step();
        chk("R10 clear", 64'(status), 64'd0);
        chk("R11 irq cleared", 64'(irq), 64'd0);
        wr(3'd4, 32'h00);

        // R7 index mismatch
        rsp_vec = mk_short(6'd9, 32'h0BAD_F00D);
        run_cmd({18'd0, 6'd8, 3'd0, 5'b11001}, 32'd0, 32'h3, 48, 0, 0);
        chk("R7 index err", 64'(status), 64'h12);
        run_cmd({18'd0, 6'd8, 3'd0, 5'b01001}, 32'd0, 32'h3, 48, 0, 0);
        chk("R7 index check off", 64'(status), 64'h01);

        // R8 timeout and its boundary
        run_cmd({18'd0, 6'd1, 3'd0, 5'b00001}, 32'd8, 32'h4, 0, 0, 0);
        chk("R8 silent card", 64'(status), 64'h06);
        rsp_vec = mk_short(6'd1, 32'h7777_0000);
        run_cmd({18'd0, 6'd1, 3'd0, 5'b11001}, 32'd8, 32'h4, 48, 7, 0);
        chk("R8 last strobe ok", 64'(status), 64'h01);
        run_cmd({18'd0, 6'd1, 3'd0, 5'b11001}, 32'd8, 32'h4, 48, 8, 0);
        chk("R8 one late", 64'(status), 64'h06);
        run_cmd({18'd0, 6'd1, 3'd0, 5'b11001}, 32'd0, 32'h4, 48, 60, 0);
        chk("R8 zero disables", 64'(status), 64'h01);

        // R9 busy wait
        rsp_vec = mk_short(6'd7, 32'h1111_2222);
        run_cmd({18'd0, 6'd7, 3'd0, 5'b11101}, 32'd100, 32'h5, 48, 1, 6);
        chk("R9 busy release", 64'(status), 64'h01);
        run_cmd({18'd0, 6'd7, 3'd0, 5'b11101}, 32'd10, 32'h5, 48, 1, 400);
        chk("R9 busy timeout", 64'(status), 64'h06);
        run_cmd({18'd0, 6'd7, 3'd0, 5'b00100}, 32'd0, 32'h5, 0, 0, 4);
        chk("R9 busy no reply", 64'(status), 64'h01);

        // R12 writes during flight are ignored
        rsp_vec = mk_short(6'd5, 32'h3333_4444);
        mid_cw = {18'd0, 6'd9, 3'd0, 5'b11001};
        midw = 1'b1;
        run_cmd({18'd0, 6'd5, 3'd0, 5'b11001}, 32'd0, 32'hA5A5_0001, 48, 3, 0);
        chk("R12 frame intact", 64'(tx_bits), 64'(exp_frame(6'd5, 32'hA5A5_0001)));
        chk("R12 no relaunch", 64'(tx_n), 64'd48);
        chk("R12 command kept", 64'(status), 64'h01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule